// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Processor Core

This block is a 64-bit processor core that completes one instruction on every clock edge. It covers register-to-register add, subtract, bitwise and and bitwise or; doubleword load and store with a signed byte offset; compare-and-branch-if-zero; and an unconditional relative branch. The core holds the program counter, a 32-entry register file, a main opcode decoder, a second-level ALU function decoder, the ALU, the offset sign extenders and the next-PC selection. Instruction and data storage are small internal arrays.

The arrays are filled through a backdoor port while reset is held low. Once reset is released, the core fetches from byte address 0. Results leave the core only through the data array, which can be read back through the same backdoor index, and through the program counter output. A program therefore ends by storing the registers it wants observed and then branching to itself.

Top module: `sc_core`

## Requirements
- R1: With ADD (bits 31:21 = 10001011000), SUB (11001011000), AND (10001010000) or ORR (10101010000), the core writes Rn op Rm to Rd. Rn is bits 9:5, Rm is bits 20:16 and Rd is bits 4:0. SUB computes Rn minus Rm.
- R2: LDUR (bits 31:21 = 11111000010) forms the address Rn + sign-extended bits 20:12 and writes the addressed doubleword to Rt (bits 4:0). The data array index is address bits 7:3. A negative offset reaches below the base.
- R3: STUR (bits 31:21 = 11111000000) writes Rt (bits 4:0) to the doubleword at Rn + sign-extended bits 20:12 and leaves every register unchanged.
- R4: CBZ (bits 31:24 = 10110100) tests Rt (bits 4:0). When Rt is zero, the next PC is PC + (sign-extended bits 23:5 shifted left by 2). Otherwise the next PC is PC + 4.
- R5: B (bits 31:26 = 000101) sets the next PC to PC + (sign-extended bits 25:0 shifted left by 2). Backward offsets are negative.
- R6: Every instruction that does not branch advances the PC by 4.
- R7: Register 31 always reads as zero, and writes to it are discarded.
- R8: An instruction with no recognised opcode writes neither a register nor memory, and the PC advances by 4.
- R9: While reset is asserted, the PC is 0 and no register or data-array write happens, whatever instruction sits at address 0.
- R10: Loads and stores run the ALU as an adder, CBZ runs it as a pass of its second operand, and R-type instructions take the ALU function from the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_ld_en | input | 1 | Backdoor write strobe for the instruction array |
| imem_ld_idx | input | 6 | Word index for a backdoor instruction write |
| imem_ld_word | input | 32 | Instruction word to write |
| dmem_ld_en | input | 1 | Backdoor write strobe for the data array |
| dmem_bd_idx | input | 5 | Doubleword index for a backdoor data write or read |
| dmem_ld_word | input | 64 | Doubleword to write |
| dmem_rd_word | output | 64 | Data array contents at dmem_bd_idx |
| pc_o | output | 64 | Current program counter |

## Verification
The in-RTL properties assume that the instruction array was written in full before reset was released, so that no fetched word is unknown. They also assume that no backdoor write happens while the core runs. The bench meets both assumptions: it clears every instruction word to zero, which is not a valid opcode, and gives every data word a marker. It does this with reset held low and only then writes the program. Programs read registers only after a load or an ALU result has defined them, so the branch-on-register property never sees an unknown operand. Each program ends by branching to itself, which keeps the PC in range for the rest of the run.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [10:0] OPC_ADD  = 11'b10001011000;
  localparam logic [10:0] OPC_SUB  = 11'b11001011000;
  localparam logic [10:0] OPC_AND  = 11'b10001010000;
  localparam logic [10:0] OPC_ORR  = 11'b10101010000;
  localparam logic [10:0] OPC_LDUR = 11'b11111000010;
  localparam logic [10:0] OPC_STUR = 11'b11111000000;
  localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
  localparam logic [5:0]  OPC_B    = 6'b000101;

  typedef enum logic [1:0] {
    AOP_MEM  = 2'b00,
    AOP_PASS = 2'b01,
    AOP_FUNC = 2'b10
  } aluop_e;

  typedef enum logic [3:0] {
    ALU_AND   = 4'b0000,
    ALU_OR    = 4'b0001,
    ALU_ADD   = 4'b0010,
    ALU_SUB   = 4'b0110,
    ALU_PASSB = 4'b0111,
    ALU_NOR   = 4'b1100
  } alu_fn_e;

  typedef struct packed {
    logic   rm_from_rt;  // second read port addressed by bits 4:0
    logic   use_imm;     // ALU b operand is the load/store offset
    logic   load_wb;     // register write data comes from memory
    logic   reg_we;
    logic   mem_rd;
    logic   mem_we;
    logic   cond_br;
    logic   uncond_br;
    aluop_e aluop;
  } ctl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [10:0] opc,
  output ctl_t        ctl
);

  always_comb begin
    ctl = '0;
    ctl.aluop = AOP_MEM;
    if (opc[10:5] == OPC_B) begin
      ctl.uncond_br = 1'b1;
    end else if (opc[10:3] == OPC_CBZ) begin
      ctl.cond_br    = 1'b1;
      ctl.rm_from_rt = 1'b1;
      ctl.aluop      = AOP_PASS;
    end else begin
      case (opc)
        OPC_ADD, OPC_SUB, OPC_AND, OPC_ORR: begin
          ctl.reg_we = 1'b1;
          ctl.aluop  = AOP_FUNC;
        end
        OPC_LDUR: begin
          ctl.use_imm = 1'b1;
          ctl.load_wb = 1'b1;
          ctl.reg_we  = 1'b1;
          ctl.mem_rd  = 1'b1;
        end
        OPC_STUR: begin
          ctl.use_imm    = 1'b1;
          ctl.mem_we     = 1'b1;
          ctl.rm_from_rt = 1'b1;
        end
        default: ctl = ctl;
      endcase
    end
  end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  aluop_e      aluop,
  input  logic [10:0] opc,
  output alu_fn_e     fn
);

  always_comb begin
    fn = ALU_ADD;
    case (aluop)
      AOP_MEM:  fn = ALU_ADD;
      AOP_PASS: fn = ALU_PASSB;
      AOP_FUNC: begin
        case (opc)
          OPC_SUB: fn = ALU_SUB;
          OPC_AND: fn = ALU_AND;
          OPC_ORR: fn = ALU_OR;
          default: fn = ALU_ADD;
        endcase
      end
      default:  fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_PASSB: y = b;
      ALU_NOR:   y = ~(a | b);
      default:   y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 64,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr1,
  input  logic [$clog2(N)-1:0] raddr2,
  output logic [W-1:0]         rdata1,
  output logic [W-1:0]         rdata2
);

  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] ZREG = AW'(N - 1);

  logic [W-1:0] regs [N];
  logic         wr_en;

  assign wr_en = we && (waddr != ZREG);

  always_ff @(posedge clk) begin
    if (wr_en) regs[waddr] <= wdata;
  end

  assign rdata1 = (raddr1 == ZREG) ? '0 : regs[raddr1];
  assign rdata2 = (raddr2 == ZREG) ? '0 : regs[raddr2];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int IMEM_DEPTH  = 64,
  parameter int DMEM_DEPTH  = 32,
  parameter int NREGS       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          imem_ld_en,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_ld_idx,
  input  logic [31:0]                   imem_ld_word,
  input  logic                          dmem_ld_en,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dmem_bd_idx,
  input  logic [XLEN-1:0]               dmem_ld_word,
  output logic [XLEN-1:0]               dmem_rd_word,
  output logic [XLEN-1:0]               pc_o
);

  localparam int IA = $clog2(IMEM_DEPTH);
  localparam int DA = $clog2(DMEM_DEPTH);
  localparam int RA = $clog2(NREGS);

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // fetch
  logic [XLEN-1:0] pc_q, pc_d;
  logic [31:0]     imem [IMEM_DEPTH];
  logic [31:0]     instr;

  always_ff @(posedge clk) begin
    if (imem_ld_en) imem[imem_ld_idx] <= imem_ld_word;
  end
  assign instr = imem[pc_q[IA+1:2]];

  // decode
  ctl_t    ctl;
  alu_fn_e alu_fn;

  sc_main_ctrl u_main (.opc(instr[31:21]), .ctl(ctl));
  sc_alu_ctrl  u_aluc (.aluop(ctl.aluop), .opc(instr[31:21]), .fn(alu_fn));

  // register file
  logic [RA-1:0]   rs2_addr;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wdata;
  logic            rf_we;

  assign rs2_addr = ctl.rm_from_rt ? instr[4:0] : instr[20:16];
  assign rf_we    = ctl.reg_we & rst_n_s;

  sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk    (clk),
    .we     (rf_we),
    .waddr  (instr[4:0]),
    .wdata  (rf_wdata),
    .raddr1 (instr[9:5]),
    .raddr2 (rs2_addr),
    .rdata1 (rf_rd1),
    .rdata2 (rf_rd2)
  );

  // execute
  logic [XLEN-1:0] mem_off, alu_b, alu_y;
  logic            alu_zero;

  assign mem_off = {{(XLEN-9){instr[20]}}, instr[20:12]};
  assign alu_b   = ctl.use_imm ? mem_off : rf_rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rf_rd1),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [DA-1:0]   d_idx;
  logic [XLEN-1:0] ld_data;
  logic            dm_we;

  assign d_idx   = alu_y[DA+2:3];
  assign dm_we   = ctl.mem_we & rst_n_s;
  assign ld_data = dmem[d_idx];

  always_ff @(posedge clk) begin
    if (dmem_ld_en)  dmem[dmem_bd_idx] <= dmem_ld_word;
    else if (dm_we)  dmem[d_idx]       <= rf_rd2;
  end
  assign dmem_rd_word = dmem[dmem_bd_idx];

  assign rf_wdata = ctl.load_wb ? ld_data : alu_y;

  // next PC
  logic [XLEN-1:0] br_off, br_tgt, pc_inc;
  logic            take;

  always_comb begin
    if (ctl.uncond_br) br_off = {{(XLEN-26){instr[25]}}, instr[25:0]};
    else               br_off = {{(XLEN-19){instr[23]}}, instr[23:5]};
    br_tgt = pc_q + (br_off << 2);
    pc_inc = pc_q + XLEN'(4);
    take   = ctl.uncond_br | (ctl.cond_br & alu_zero);
    pc_d   = take ? br_tgt : pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // properties
  a_r6_seq_pc: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl.uncond_br && !ctl.cond_br) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r4_cbz_nonzero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl.cond_br && (rf_rd2 != '0)) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r5_uncond: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl.uncond_br |=>
      (pc_q == $past(pc_q + ({{(XLEN-26){instr[25]}}, instr[25:0]} << 2))));

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n_s)
    pc_q[1:0] == 2'b00);

  a_r3_store_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(dm_we && rf_we));

  a_r10_mem_adds: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl.mem_rd || ctl.mem_we) |-> (alu_fn == ALU_ADD));

  a_r10_cbz_pass: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl.cond_br |-> (alu_fn == ALU_PASSB));

endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam logic [10:0] K_ADD  = 11'b10001011000;
  localparam logic [10:0] K_SUB  = 11'b11001011000;
  localparam logic [10:0] K_AND  = 11'b10001010000;
  localparam logic [10:0] K_ORR  = 11'b10101010000;
  localparam logic [10:0] K_LDUR = 11'b11111000010;
  localparam logic [10:0] K_STUR = 11'b11111000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_ld_en = 1'b0;
  logic [5:0]  imem_ld_idx = '0;
  logic [31:0] imem_ld_word = '0;
  logic        dmem_ld_en = 1'b0;
  logic [4:0]  dmem_bd_idx = '0;
  logic [63:0] dmem_ld_word = '0;
  logic [63:0] dmem_rd_word;
  logic [63:0] pc_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_ld_en(imem_ld_en), .imem_ld_idx(imem_ld_idx), .imem_ld_word(imem_ld_word),
    .dmem_ld_en(dmem_ld_en), .dmem_bd_idx(dmem_bd_idx), .dmem_ld_word(dmem_ld_word),
    .dmem_rd_word(dmem_rd_word), .pc_o(pc_o)
  );

  function automatic logic [31:0] enc_r(logic [10:0] op, int rm, int rn, int rd);
    return {op, 5'(rm), 6'b0, 5'(rn), 5'(rd)};
  endfunction
  function automatic logic [31:0] enc_d(logic [10:0] op, int off, int rn, int rt);
    logic [31:0] o = off;
    return {op, o[8:0], 2'b00, 5'(rn), 5'(rt)};
  endfunction
  function automatic logic [31:0] enc_cbz(int off, int rt);
    logic [31:0] o = off;
    return {8'b10110100, o[18:0], 5'(rt)};
  endfunction
  function automatic logic [31:0] enc_b(int off);
    logic [31:0] o = off;
    return {6'b000101, o[25:0]};
  endfunction
  function automatic logic [63:0] mk(int i);
    return 64'hDEAD_BEEF_0000_0000 + 64'(i);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got=timeout exp=done");
    summary();
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put_i(input int idx, input logic [31:0] w);
    @(negedge clk);
    imem_ld_en = 1'b1; imem_ld_idx = 6'(idx); imem_ld_word = w;
    @(negedge clk);
    imem_ld_en = 1'b0;
  endtask

  task automatic put_d(input int idx, input logic [63:0] v);
    @(negedge clk);
    dmem_ld_en = 1'b1; dmem_bd_idx = 5'(idx); dmem_ld_word = v;
    @(negedge clk);
    dmem_ld_en = 1'b0;
  endtask

  task automatic get_d(input int idx, output logic [63:0] v);
    @(negedge clk);
    dmem_bd_idx = 5'(idx);
    #1 v = dmem_rd_word;
  endtask

  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) put_i(i, 32'h0);
    for (int i = 0; i < 32; i++) put_d(i, mk(i));
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n + 2) @(posedge clk);
  endtask

  // reset holds the PC and blocks a store sitting at address 0
  task automatic t_reset();
    logic [63:0] v;
    begin_test();
    put_i(0, enc_d(K_STUR, 0, 31, 31));
    repeat (6) @(posedge clk);
    #1 chk("R9 pc held at zero in reset", pc_o, 64'd0);
    get_d(0, v); chk("R9 no store while in reset", v, mk(0));
    run(3);
    get_d(0, v); chk("R3 store after release writes zero", v, 64'd0);
  endtask

  task automatic t_alu();
    logic [63:0] a = 64'h0123_4567_89AB_CDEF, b = 64'h0F0F_F0F0_1234_5678, v;
    begin_test();
    put_d(0, a); put_d(1, b);
    put_i(0,  enc_d(K_LDUR, 0, 31, 1));
    put_i(1,  enc_d(K_LDUR, 8, 31, 2));
    put_i(2,  enc_r(K_ADD, 2, 1, 3));
    put_i(3,  enc_r(K_SUB, 2, 1, 4));
    put_i(4,  enc_r(K_AND, 2, 1, 5));
    put_i(5,  enc_r(K_ORR, 2, 1, 6));
    put_i(6,  enc_d(K_STUR, 16, 31, 3));
    put_i(7,  enc_d(K_STUR, 24, 31, 4));
    put_i(8,  enc_d(K_STUR, 32, 31, 5));
    put_i(9,  enc_d(K_STUR, 40, 31, 6));
    put_i(10, enc_b(0));
    run(20);
    get_d(2, v); chk("R1 ADD result", v, a + b);
    get_d(3, v); chk("R1 SUB result", v, a - b);
    get_d(4, v); chk("R1 AND result", v, a & b);
    get_d(5, v); chk("R1 ORR result", v, a | b);
    #1 chk("R6 PC advanced to self branch", pc_o, 64'd40);
  endtask

  task automatic t_load_neg();
    logic [63:0] v;
    begin_test();
    put_d(0, 64'd64);
    put_d(7, 64'h5555_AAAA_1234_0042);
    put_i(0, enc_d(K_LDUR, 0, 31, 1));
    put_i(1, enc_d(K_LDUR, -8, 1, 2));
    put_i(2, enc_d(K_STUR, 8, 31, 2));
    put_i(3, enc_b(0));
    run(10);
    get_d(1, v); chk("R2 R10 negative offset load", v, 64'h5555_AAAA_1234_0042);
  endtask

  task automatic t_zero_reg();
    logic [63:0] v;
    begin_test();
    put_d(0, 64'd5); put_d(1, 64'd9);
    put_i(0, enc_d(K_LDUR, 0, 31, 1));
    put_i(1, enc_d(K_LDUR, 8, 31, 2));
    put_i(2, enc_r(K_ADD, 2, 1, 31));
    put_i(3, enc_d(K_STUR, 16, 31, 31));
    put_i(4, enc_r(K_ORR, 1, 31, 3));
    put_i(5, enc_d(K_STUR, 24, 31, 3));
    put_i(6, enc_d(K_LDUR, 8, 31, 31));
    put_i(7, enc_d(K_STUR, 32, 31, 31));
    put_i(8, enc_b(0));
    run(15);
    get_d(2, v); chk("R7 ADD into X31 discarded", v, 64'd0);
    get_d(3, v); chk("R7 X31 reads zero as operand", v, 64'd5);
    get_d(4, v); chk("R7 load into X31 discarded", v, 64'd0);
  endtask

  task automatic t_cbz();
    logic [63:0] v;
    begin_test();
    put_d(0, 64'd0); put_d(1, 64'd5);
    put_i(0, enc_d(K_LDUR, 0, 31, 1));
    put_i(1, enc_d(K_LDUR, 8, 31, 2));
    put_i(2, enc_cbz(3, 2));
    put_i(3, enc_d(K_STUR, 16, 31, 2));
    put_i(4, enc_cbz(3, 1));
    put_i(5, enc_d(K_STUR, 24, 31, 2));
    put_i(6, enc_d(K_STUR, 24, 31, 2));
    put_i(7, enc_d(K_STUR, 32, 31, 1));
    put_i(8, enc_b(0));
    run(15);
    get_d(2, v); chk("R4 CBZ on nonzero falls through", v, 64'd5);
    get_d(3, v); chk("R4 R10 CBZ on zero skips", v, mk(3));
    get_d(4, v); chk("R4 CBZ target executed", v, 64'd0);
    #1 chk("R4 final PC", pc_o, 64'd32);
  endtask

  task automatic t_loop();
    logic [63:0] v;
    begin_test();
    put_d(0, 64'd3); put_d(1, 64'd1); put_d(2, 64'd10);
    put_i(0, enc_d(K_LDUR, 0, 31, 1));
    put_i(1, enc_d(K_LDUR, 8, 31, 2));
    put_i(2, enc_d(K_LDUR, 16, 31, 3));
    put_i(3, enc_cbz(4, 1));
    put_i(4, enc_r(K_ADD, 3, 3, 3));
    put_i(5, enc_r(K_SUB, 2, 1, 1));
    put_i(6, enc_b(-3));
    put_i(7, enc_d(K_STUR, 24, 31, 3));
    put_i(8, enc_b(0));
    run(40);
    get_d(3, v); chk("R5 backward branch loop result", v, 64'd80);
    #1 chk("R5 loop exit PC", pc_o, 64'd32);
  endtask

  task automatic t_unknown();
    logic [63:0] v;
    begin_test();
    put_d(0, 64'd77);
    put_i(0, enc_d(K_LDUR, 0, 31, 1));
    put_i(1, 32'hFFFF_FFE1);
    put_i(2, enc_b(2));
    put_i(3, enc_d(K_STUR, 8, 31, 1));
    put_i(4, enc_d(K_STUR, 16, 31, 1));
    put_i(5, enc_b(0));
    run(15);
    get_d(1, v); chk("R5 forward branch skips store", v, mk(1));
    get_d(2, v); chk("R8 unknown opcode leaves X1", v, 64'd77);
    #1 chk("R8 R6 final PC", pc_o, 64'd20);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_load_neg();
    t_zero_reg();
    t_cbz();
    t_loop();
    t_unknown();
    summary();
  end

endmodule